// File: doc/BRIEF.md
# Dual-Mode Booth Partial Product Generator

This block forms the radix-4 Booth partial product rows for a floating-point significand multiplier that works either at full width or as two packed narrow lanes. Set to wide mode, it treats the two operand words as one 53-bit significand pair (implicit leading one included) and emits 27 rows. Set to packed mode, it treats each word as two 24-bit significands and emits two groups of 13 rows. The lower product's group goes to the right-hand, top rows of a 106-column array. The upper product's group goes to the left-hand, bottom rows. A 10-column gap between the groups keeps carries from crossing. The single row between the two groups is used only in wide mode.

Every row is a 106-bit vector already aligned to absolute array columns. The rows carry sign-encoding prefix bits instead of sign extension. The increment that completes a negated row is folded into the next row, just under that row's own field. A downstream compression tree can therefore add the rows column by column and needs no correction term. The block is purely combinational.

Top module: `mpm_booth_ppgen`

## Requirements
- R1: With `mode_dbl`=1 the significands are `op_a[52:0]` and `op_b[52:0]`. With `mode_dbl`=0 lane 0 uses bits [23:0] and lane 1 uses bits [55:32] of each word. All other operand bits have no effect on any row.
- R2: With `mode_dbl`=1 the sum of all 27 rows modulo 2^106 equals the 106-bit product of the two 53-bit significands.
- R3: With `mode_dbl`=0, bits [47:0] of the row sum equal the lane 0 product, and bits [105:58] equal the lane 1 product.
- R4: With `mode_dbl`=0, row 13 is all zeros.
- R5: With `mode_dbl`=0, rows 0 to 12 have no set bit at column 58 or above, and rows 14 to 26 have no set bit below column 58.
- R6: In wide mode, row k takes its Booth digit from multiplier bits (2k+1, 2k, 2k-1), where bit -1 and bit 53 read as zero. A digit of +1 puts {0, A} into columns [2k+53:2k] of row k, and rows whose digit is zero carry nothing in their field. In wide mode no row k of 2 or more has a set bit below column 2k-2.
- R7: For a negative digit, the field holds the bitwise complement of |digit|·A over 54 bits (25 bits in packed mode). The next row then carries a one at the negated row's lowest column and a zero in the column above it.
- R8: The prefix starts just above the field (column 2k+54 in wide mode). The first row carries n, n, p in ascending columns. Each middle row carries p and then a constant one. The last row carries p alone. Here n is 1 when the row's digit is negative, and p is the complement of n.
- R9: The top row of each product never has a negative digit. In wide mode with an all-ones multiplier, row 26 equals 2A shifted to column 52, truncated at column 105.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_dbl | input | 1 | 1 selects one wide product, 0 selects two packed lanes |
| op_a | input | 64 | Multiplicand significand word |
| op_b | input | 64 | Multiplier significand word (Booth recoded) |
| pp_rows | output | 27 x 106 | Column-aligned partial product rows, row 0 first |

## Verification
On every input change, the in-line checks confirm four things. The middle row is idle in packed mode. Each packed row keeps to its own lane's columns. The top row of a product is never negated. A wide row has no bit below the slot for the increment it receives. They also confirm that a negative digit only comes from a triplet whose top bit is set. Whether the rows actually add up to the right products can only be shown by the bench's scenarios. The same holds for the exact field, prefix and increment layout of chosen rows, and for the operand bits outside the lanes having no effect. The bench covers random significands and the corners: all ones, minimum normal and alternating bits.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  // Booth radix-4 digit values
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_M1   = 3'd3,
    DIG_M2   = 3'd4
  } booth_dig_e;

  // Triplet (upper, middle, lower) -> digit = -2*upper + middle + lower
  function automatic booth_dig_e booth_decode(input logic [2:0] t);
    booth_dig_e d;
    case (t)
      3'b001, 3'b010: d = DIG_P1;
      3'b011:         d = DIG_P2;
      3'b100:         d = DIG_M2;
      3'b101, 3'b110: d = DIG_M1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

  function automatic logic dig_is_neg(input booth_dig_e d);
    return (d == DIG_M1) || (d == DIG_M2);
  endfunction

endpackage

// File: rtl/mpm_lane_sel.sv
module mpm_lane_sel
  import mpm_pkg::*;
#(
  parameter int DBL_W     = 53,
  parameter int SGL_W     = 24,
  parameter int ARR_W     = 106,
  parameter int D_ROWS    = 27,
  parameter int S_ROWS    = 13,
  parameter int COL_W     = 7,
  parameter int ROW       = 0
) (
  input  logic             mode_dbl,
  input  logic [DBL_W-1:0] dbl_a,
  input  logic [DBL_W-1:0] dbl_b,
  input  logic [SGL_W-1:0] sgl_a,
  input  logic [SGL_W-1:0] sgl_b,
  output logic [DBL_W-1:0] mcand,
  output logic [2:0]       trip,
  output logic [COL_W-1:0] col,
  output logic             is_first,
  output logic             is_last,
  output logic             active
);
  localparam int MID       = S_ROWS;
  localparam bit IN_UPPER  = (ROW > MID);
  localparam bit IS_MID    = (ROW == MID);
  localparam int SJ        = IS_MID ? 0 : (IN_UPPER ? ROW - MID - 1 : ROW);
  localparam int UPPER_COL = ARR_W - 2 * SGL_W;
  localparam int S_COL     = IN_UPPER ? UPPER_COL + 2 * SJ : 2 * SJ;

  // multiplier extended: one zero below, zero(s) above to fill all triplets
  logic [DBL_W+1:0] b_wide;
  logic [SGL_W+2:0] b_lane;

  assign b_wide = {1'b0, dbl_b, 1'b0};
  assign b_lane = {2'b00, sgl_b, 1'b0};

  // first multiplexer level: the mode picks the operand form for this row
  always_comb begin
    if (mode_dbl) begin
      mcand    = dbl_a;
      trip     = b_wide[2*ROW +: 3];
      col      = COL_W'(2 * ROW);
      is_first = (ROW == 0);
      is_last  = (ROW == D_ROWS - 1);
      active   = 1'b1;
    end else begin
      mcand    = DBL_W'(sgl_a);
      trip     = b_lane[2*SJ +: 3];
      col      = COL_W'(S_COL);
      is_first = (SJ == 0);
      is_last  = (SJ == S_ROWS - 1);
      active   = !IS_MID;
    end
  end

endmodule

// File: rtl/mpm_booth_enc.sv
module mpm_booth_enc
  import mpm_pkg::*;
(
  input  logic [2:0] trip,
  input  logic       active,
  output booth_dig_e dig,
  output logic       neg
);
  always_comb begin
    dig = active ? booth_decode(trip) : DIG_ZERO;
    neg = dig_is_neg(dig);
  end

  // a negated multiple can only come from a triplet whose top bit is set
  always_comb begin
    p_neg_from_top_r7: assert (!neg || trip[2])
      else $error("negative digit from triplet %b", trip);
  end

endmodule

// File: rtl/mpm_pp_row.sv
module mpm_pp_row
  import mpm_pkg::*;
#(
  parameter int DBL_W = 53,
  parameter int SGL_W = 24,
  parameter int ARR_W = 106,
  parameter int COL_W = 7
) (
  input  logic             mode_dbl,
  input  logic [DBL_W-1:0] mcand,
  input  booth_dig_e       dig,
  input  logic             is_first,
  input  logic             is_last,
  input  logic             active,
  input  logic [COL_W-1:0] col,
  input  logic             hot_in,
  input  logic [COL_W-1:0] hot_col,
  output logic [ARR_W-1:0] row
);
  localparam int MAG_W = DBL_W + 1;
  localparam logic [MAG_W-1:0] SGL_MASK = MAG_W'({(SGL_W+1){1'b1}});
  localparam logic [COL_W-1:0] K_DBL    = COL_W'(DBL_W + 1);
  localparam logic [COL_W-1:0] K_SGL    = COL_W'(SGL_W + 1);

  logic [MAG_W-1:0] one_x, two_x, fmask, field;
  logic             sgn_n, sgn_p;
  logic [2:0]       prefix;
  logic [COL_W-1:0] kpos;
  logic [ARR_W-1:0] rel;

  always_comb begin
    one_x = {1'b0, mcand};
    two_x = {mcand, 1'b0};
    fmask = mode_dbl ? '1 : SGL_MASK;
    // second multiplexer level: 5:1 pick by the Booth digit
    case (dig)
      DIG_P1:  field = one_x;
      DIG_P2:  field = two_x;
      DIG_M1:  field = ~one_x & fmask;
      DIG_M2:  field = ~two_x & fmask;
      default: field = '0;
    endcase
    sgn_n = dig_is_neg(dig);
    sgn_p = ~sgn_n;
    if (is_first)     prefix = {sgn_p, sgn_n, sgn_n};
    else if (is_last) prefix = {2'b00, sgn_p};
    else              prefix = {1'b0, 1'b1, sgn_p};
    kpos = mode_dbl ? K_DBL : K_SGL;
    rel  = ARR_W'(field) | (ARR_W'(prefix) << kpos);
    row  = active ? ((rel << col) | (ARR_W'(hot_in) << hot_col)) : '0;
  end

endmodule

// File: rtl/mpm_booth_ppgen.sv
module mpm_booth_ppgen
  import mpm_pkg::*;
#(
  parameter  int WORD_W    = 64,
  parameter  int DBL_W     = 53,
  parameter  int SGL_W     = 24,
  parameter  int LANE1_LSB = 32,
  localparam int ARR_W     = 2 * DBL_W,
  localparam int ROWS      = (DBL_W + 2) / 2,
  localparam int S_ROWS    = (SGL_W + 2) / 2,
  localparam int COL_W     = $clog2(ARR_W),
  localparam int UPPER_COL = ARR_W - 2 * SGL_W,
  localparam int USE_W     = LANE1_LSB + SGL_W
) (
  input  logic                       mode_dbl,
  input  logic [WORD_W-1:0]          op_a,
  input  logic [WORD_W-1:0]          op_b,
  output logic [ROWS-1:0][ARR_W-1:0] pp_rows
);
  logic [ROWS-1:0]            row_neg;
  logic [ROWS-1:0]            row_last;
  logic [ROWS-1:0][COL_W-1:0] row_col;
  logic                       unused_tail;

  assign unused_tail = ^{op_a[WORD_W-1:USE_W], op_b[WORD_W-1:USE_W], row_col[ROWS-1]};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int LANE_BASE = (r > S_ROWS) ? LANE1_LSB : 0;

    logic [DBL_W-1:0] mc;
    logic [2:0]       tr;
    booth_dig_e       dg;
    logic             fst, act, hin;
    logic [COL_W-1:0] hcol;

    mpm_lane_sel #(
      .DBL_W(DBL_W), .SGL_W(SGL_W), .ARR_W(ARR_W), .D_ROWS(ROWS),
      .S_ROWS(S_ROWS), .COL_W(COL_W), .ROW(r)
    ) u_sel (
      .mode_dbl (mode_dbl),
      .dbl_a    (op_a[DBL_W-1:0]),
      .dbl_b    (op_b[DBL_W-1:0]),
      .sgl_a    (op_a[LANE_BASE +: SGL_W]),
      .sgl_b    (op_b[LANE_BASE +: SGL_W]),
      .mcand    (mc),
      .trip     (tr),
      .col      (row_col[r]),
      .is_first (fst),
      .is_last  (row_last[r]),
      .active   (act)
    );

    mpm_booth_enc u_enc (
      .trip   (tr),
      .active (act),
      .dig    (dg),
      .neg    (row_neg[r])
    );

    // increment of a negated row lands in the next row, at that row's LSB column
    if (r == 0) begin : g_head
      assign hin  = 1'b0;
      assign hcol = '0;
    end else begin : g_chain
      assign hin  = row_neg[r-1];
      assign hcol = row_col[r-1];
    end

    mpm_pp_row #(
      .DBL_W(DBL_W), .SGL_W(SGL_W), .ARR_W(ARR_W), .COL_W(COL_W)
    ) u_row (
      .mode_dbl (mode_dbl),
      .mcand    (mc),
      .dig      (dg),
      .is_first (fst),
      .is_last  (row_last[r]),
      .active   (act),
      .col      (row_col[r]),
      .hot_in   (hin),
      .hot_col  (hcol),
      .row      (pp_rows[r])
    );

    // top row of each product is never negated
    always_comb begin
      p_top_row_pos_r9: assert (!(row_last[r] && row_neg[r]))
        else $error("row %0d negated although last", r);
    end

    if (r == S_ROWS) begin : g_mid_chk
      always_comb begin
        if (!mode_dbl)
          p_mid_row_idle_r4: assert (pp_rows[r] == '0)
            else $error("middle row busy in packed mode");
      end
    end else if (r < S_ROWS) begin : g_low_chk
      always_comb begin
        if (!mode_dbl)
          p_low_lane_clear_r5: assert (pp_rows[r][ARR_W-1:UPPER_COL] == '0)
            else $error("row %0d leaks into upper lane", r);
      end
    end else begin : g_up_chk
      always_comb begin
        if (!mode_dbl)
          p_up_lane_clear_r5: assert (pp_rows[r][UPPER_COL-1:0] == '0)
            else $error("row %0d leaks into lower lane", r);
      end
    end

    if (r >= 2) begin : g_floor_chk
      always_comb begin
        if (mode_dbl)
          p_row_floor_r6: assert (pp_rows[r][2*r-3:0] == '0)
            else $error("row %0d has bits below its increment slot", r);
      end
    end
  end

endmodule

// File: tb/test_mpm_booth_ppgen.sv
module test_mpm_booth_ppgen;
  localparam int AW = 106;
  localparam int NR = 27;
  localparam logic [AW-1:0] M54 = AW'({54{1'b1}});

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_dbl = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [NR-1:0][AW-1:0] pp_rows;
  logic [NR-1:0][AW-1:0] saved;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mpm_booth_ppgen i_mpm_booth_ppgen (
    .mode_dbl (mode_dbl),
    .op_a     (op_a),
    .op_b     (op_b),
    .pp_rows  (pp_rows)
  );

  function automatic logic [AW-1:0] row_sum();
    logic [AW-1:0] s = '0;
    for (int r = 0; r < NR; r++) s += pp_rows[r];
    return s;
  endfunction

  function automatic logic [AW-1:0] wide_prod(input logic [52:0] a, input logic [52:0] b);
    return AW'(a) * AW'(b);
  endfunction

  function automatic logic [47:0] lane_prod(input logic [23:0] a, input logic [23:0] b);
    return 48'(a) * 48'(b);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    mode_dbl = m;
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  // R1 junk in ignored bits, R2 sum
  task automatic run_wide(input logic [52:0] a, input logic [52:0] b);
    logic [31:0] j = $urandom;
    apply(1'b1, {j[10:0], a}, {j[21:11], b});
    check("R2 wide sum", row_sum(), wide_prod(a, b));
  endtask

  // R1 junk, R3 lane sums, R4 idle middle row, R5 separation
  task automatic run_lanes(input logic [23:0] a0, input logic [23:0] b0,
                           input logic [23:0] a1, input logic [23:0] b1);
    logic [31:0] j = $urandom;
    logic [AW-1:0] s;
    logic leak = 1'b0;
    apply(1'b0, {j[7:0], a1, j[15:8], a0}, {j[23:16], b1, j[31:24], b0});
    s = row_sum();
    check("R3 lane0", AW'(s[47:0]), AW'(lane_prod(a0, b0)));
    check("R3 lane1", AW'(s[105:58]), AW'(lane_prod(a1, b1)));
    check("R4 middle row", pp_rows[13], '0);
    for (int r = 0; r < 13; r++) if (pp_rows[r][105:58] != '0) leak = 1'b1;
    for (int r = 14; r < NR; r++) if (pp_rows[r][57:0] != '0) leak = 1'b1;
    check("R5 lane separation", AW'(leak), '0);
  endtask

  initial begin : main
    logic [52:0] a, b;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 zero operands", row_sum(), '0);

    // wide corners
    run_wide({53{1'b1}}, {53{1'b1}});
    run_wide(53'h1 << 52, 53'h1 << 52);
    run_wide({1'b1, {26{2'b01}}}, {1'b1, {26{2'b10}}});
    run_wide({53{1'b1}}, 53'h1 << 52);
    run_wide(53'h1, {53{1'b1}});

    // lane corners
    run_lanes(24'hffffff, 24'hffffff, 24'h800000, 24'h800000);
    run_lanes(24'haaaaaa, 24'h555555, 24'hffffff, 24'h800000);
    run_lanes(24'h800001, 24'hffffff, 24'hd55555, 24'haaaaab);

    // R1 ignored bits: same rows with and without junk above the significands
    apply(1'b1, {11'h0, 53'h1_2345_6789_abcd}, {11'h0, 53'h1_fedc_ba98_7654});
    saved = pp_rows;
    apply(1'b1, {11'h7ff, 53'h1_2345_6789_abcd}, {11'h5a5, 53'h1_fedc_ba98_7654});
    check("R1 wide junk", AW'(saved != pp_rows), '0);
    apply(1'b0, {8'h00, 24'h9abcde, 8'h00, 24'h876543}, {8'h00, 24'hc0ffee, 8'h00, 24'hbadcaf});
    saved = pp_rows;
    apply(1'b0, {8'hff, 24'h9abcde, 8'h3c, 24'h876543}, {8'ha5, 24'hc0ffee, 8'hff, 24'hbadcaf});
    check("R1 lane junk", AW'(saved != pp_rows), '0);

    // R6 placement of a +1 digit; other fields empty
    a = 53'h1_0f0f_3c3c_9696 | (53'h1 << 52);
    foreach (int_k_list[i]) begin end
    for (int k = 0; k <= 26; k += 13) begin
      logic bad = 1'b0;
      apply(1'b1, {11'h0, a}, 64'(53'h1 << (2 * k)));
      check("R6 +1 field", (pp_rows[k] >> (2 * k)) & M54, AW'(a));
      for (int r = 0; r < NR; r++)
        if (r != k && ((pp_rows[r] >> (2 * r)) & M54) != '0) bad = 1'b1;
      check("R6 empty fields", AW'(bad), '0);
    end

    // R7 negative digit: complemented field and increment in next row
    for (int k = 0; k <= 25; k += 5) begin
      apply(1'b1, {11'h0, a}, 64'(53'h3 << (2 * k)));
      check("R7 complement", (pp_rows[k] >> (2 * k)) & M54, (~AW'(a)) & M54);
      check("R7 increment", AW'((pp_rows[k+1] >> (2 * k)) & AW'(3)), AW'(1));
    end

    // R8 prefix bits
    apply(1'b1, {11'h0, a}, 64'h2);
    check("R8 first row negative", AW'(pp_rows[0][56:54]), AW'(3'b011));
    apply(1'b1, {11'h0, a}, 64'h1);
    check("R8 first row positive", AW'(pp_rows[0][56:54]), AW'(3'b100));
    apply(1'b1, {11'h0, a}, 64'(53'h3 << 6));
    check("R8 middle row negative", AW'(pp_rows[3][61:60]), AW'(2'b10));
    check("R8 middle row positive", AW'(pp_rows[5][65:64]), AW'(2'b11));

    // R9 top row with all-ones multiplier
    apply(1'b1, {11'h0, a}, {11'h0, {53{1'b1}}});
    check("R9 top row", pp_rows[26], AW'(a) << 53);

    // random mix
    for (int i = 0; i < 150; i++) begin
      a = 53'({$urandom, $urandom}) | (53'h1 << 52);
      b = 53'({$urandom, $urandom}) | (53'h1 << 52);
      run_wide(a, b);
      run_lanes(24'($urandom) | 24'h800000, 24'($urandom) | 24'h800000,
                24'($urandom) | 24'h800000, 24'($urandom) | 24'h800000);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int int_k_list[1] = '{0};

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule